// File: doc/BRIEF.md
# PLL Out-of-Lock Monitor

This block watches the two phase-error strobes of a phase/frequency detector, the pump-up request and the pump-down request. It decides whether the loop has lost lock. Both strobes are sampled on a fast clock. A separate count is kept of how many consecutive samples each strobe has been high. As soon as either run goes past a programmable threshold, the block declares the loop out of lock on the next clock edge.

Releasing the flag is deliberately slower than setting it. The reference clock is delivered as a one-cycle `ref_tick` strobe that marks the first sample of each reference period. The flag drops only when a set number of complete reference periods in a row end without any over-threshold error. Any over-threshold error restarts that count from zero. This gives a fast set and a slow clear.

The result is presented twice. One output is active low and goes low while the loop is out of lock; it is intended for an external pin driver. The other is active high and is intended for a readable status register.

The decision logic is a two-state machine. `ST_OUT` means out of lock and the release count is running. `ST_LOCKED` means the loop is locked. There are three transitions:
- **T_SET**: from either state to `ST_OUT`, taken on an over-threshold sample.
- **T_RESTART**: from `ST_OUT` to `ST_OUT`, taken when a period that contained an error ends; the release count returns to zero.
- **T_RELEASE**: from `ST_OUT` to `ST_LOCKED`, taken on the `ref_tick` that ends the last clean period needed.

Top module: `pll_lock_mon`

## Requirements
- R1: Only the pump-up and pump-down strobes are treated as error inputs. Each is measured on its own, so the wider of the two in a reference period decides the outcome.
- R2: When `up_i` is high for more than `THRESH_CYC` consecutive samples, the state moves to `ST_OUT` on the edge that takes sample `THRESH_CYC+1`. A run of exactly `THRESH_CYC` samples is not an error.
- R3: `dn_i` follows the same rule as `up_i` in R2, with the same threshold.
- R4: In `ST_OUT`, the block moves to `ST_LOCKED` on the `ref_tick` edge that ends the `REL_CYC`-th consecutive reference period with no over-threshold sample. `ref_tick` high marks the first sample of a period.
- R5: An over-threshold sample at any time sets the release count to zero. A period that contained such a sample does not count as clean.
- R6: `lock_fail_n` is 0 and `ool_status` is 1 exactly while the state is `ST_OUT`. Otherwise `lock_fail_n` is 1 and `ool_status` is 0.
- R7: After reset the block is in `ST_OUT`. The partial period before the first `ref_tick` never counts as clean, so release needs `REL_CYC` full clean periods after that tick.
- R8: Width is measured without regard to period boundaries. A strobe that stays high across a `ref_tick` is judged on its total run length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Pump-up strobe from the phase detector, already synchronous to `clk` |
| dn_i | input | 1 | Pump-down strobe from the phase detector, already synchronous to `clk` |
| ref_tick | input | 1 | One-cycle marker of the first sample of each reference period |
| lock_fail_n | output | 1 | Active-low out-of-lock indication |
| ool_status | output | 1 | Active-high out-of-lock status bit |

## Verification
Both outputs are decoded directly from the state register, so they have no output pipeline stage:
- A set is visible right after the edge that samples strobe high number `THRESH_CYC+1`.
- A release is visible right after the `ref_tick` edge that closes the last clean period.

The bench drives inputs on falling edges and keeps a cycle-level model that it updates on the same rising edge as the design. It compares both outputs with that model on every falling edge, so each result is checked half a cycle after the edge where it is due. Directed checks are placed at the end of whole reference periods and cover the threshold boundary, release counting, restarts and strobes that cross a period boundary.

// File: rtl/lockmon_pkg.sv
package lockmon_pkg;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OUT    = 1'b1
    } lock_st_e;

endpackage

// File: rtl/lockmon_width.sv
// Consecutive-high run counter for one phase-error strobe; saturates at the threshold.
module lockmon_width #(
    parameter int THRESH_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic over_o
);
    localparam int CW = $clog2(THRESH_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(THRESH_CYC);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!pulse_i) begin
            run_q <= '0;
        end else if (run_q != LIMIT) begin
            run_q <= run_q + 1'b1;
        end
    end

    // current sample is high and THRESH_CYC earlier samples were high
    assign over_o = pulse_i && (run_q == LIMIT);
endmodule

// File: rtl/lockmon_fsm.sv
module lockmon_fsm
    import lockmon_pkg::*;
#(
    parameter int REL_CYC = 6,
    localparam int RCW = $clog2(REL_CYC + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wide_i,
    input  logic           ref_tick_i,
    output logic           ool_o,
    output logic [RCW-1:0] clean_cnt_o
);
    localparam logic [RCW-1:0] LAST = RCW'(REL_CYC - 1);

    lock_st_e       state_q, state_d;
    logic [RCW-1:0] cnt_q, cnt_d;
    logic           bad_q, bad_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OUT;
            cnt_q   <= '0;
            bad_q   <= 1'b1;   // partial first period never counts
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bad_q   <= bad_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        bad_d   = ref_tick_i ? wide_i : (bad_q | wide_i);
        unique case (state_q)
            ST_LOCKED: begin
                if (wide_i) begin              // T_SET
                    state_d = ST_OUT;
                    cnt_d   = '0;
                end
            end
            ST_OUT: begin
                if (wide_i) begin              // T_SET
                    cnt_d = '0;
                end else if (ref_tick_i) begin
                    if (bad_q) begin           // T_RESTART
                        cnt_d = '0;
                    end else if (cnt_q == LAST) begin  // T_RELEASE
                        state_d = ST_LOCKED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_OUT;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_LOCKED: ool_o = 1'b0;
            ST_OUT:    ool_o = 1'b1;
            default:   ool_o = 1'b1;
        endcase
    end

    assign clean_cnt_o = cnt_q;
endmodule

// File: rtl/pll_lock_mon.sv
module pll_lock_mon #(
    parameter int THRESH_CYC = 20,
    parameter int REL_CYC    = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_i,
    input  logic dn_i,
    input  logic ref_tick,
    output logic lock_fail_n,
    output logic ool_status
);
    localparam int RCW = $clog2(REL_CYC + 1);

    logic [1:0]     strobe;
    logic [1:0]     over;
    logic           wide_any;
    logic           ool;
    logic [RCW-1:0] clean_cnt;

    assign strobe = {dn_i, up_i};

    for (genvar g = 0; g < 2; g++) begin : g_meter
        lockmon_width #(.THRESH_CYC(THRESH_CYC)) u_width (
            .clk     (clk),
            .rst_n   (rst_n),
            .pulse_i (strobe[g]),
            .over_o  (over[g])
        );
    end

    assign wide_any = |over;

    lockmon_fsm #(.REL_CYC(REL_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wide_i      (wide_any),
        .ref_tick_i  (ref_tick),
        .ool_o       (ool),
        .clean_cnt_o (clean_cnt)
    );

    assign lock_fail_n = ~ool;
    assign ool_status  = ool;
endmodule

// File: rtl/lockmon_chk.sv
module lockmon_chk #(
    parameter int REL_CYC = 6,
    parameter int RCW     = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           ref_tick,
    input logic           wide_any,
    input logic           lock_fail_n,
    input logic           ool_status,
    input logic [RCW-1:0] clean_cnt
);
    AST_PIN_MIRRORS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_fail_n == !ool_status); // R6

    AST_WIDE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wide_any |=> ool_status); // R2

    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_fail_n) |-> $past(ref_tick) && !$past(wide_any)); // R4

    AST_CLEAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        clean_cnt < RCW'(REL_CYC)); // R5

    AST_RESET_OUT: assert property (@(posedge clk)
        !rst_n |=> ool_status); // R7
endmodule

bind pll_lock_mon lockmon_chk #(.REL_CYC(REL_CYC), .RCW(RCW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_tick    (ref_tick),
    .wide_any    (wide_any),
    .lock_fail_n (lock_fail_n),
    .ool_status  (ool_status),
    .clean_cnt   (clean_cnt)
);

// File: tb/pll_lock_mon_bench.sv
module pll_lock_mon_bench;
    localparam int TH      = 20;
    localparam int REL     = 6;
    localparam int REF_LEN = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_i = 1'b0, dn_i = 1'b0, ref_tick = 1'b0;
    logic lock_fail_n, ool_status;

    int checks = 0, fails = 0;
    int rem_up = 0, rem_dn = 0;

    // reference model state
    int m_uprun = 0, m_dnrun = 0, m_clean = 0;
    bit m_bad = 1'b1, m_ool = 1'b1;

    always #5 clk = ~clk;

    pll_lock_mon #(.THRESH_CYC(TH), .REL_CYC(REL)) u_pll_lock_mon (
        .clk(clk), .rst_n(rst_n), .up_i(up_i), .dn_i(dn_i), .ref_tick(ref_tick),
        .lock_fail_n(lock_fail_n), .ool_status(ool_status)
    );

    function automatic bit is_wide(bit u, bit d, int ur, int dr);
        return (u && ur >= TH) || (d && dr >= TH);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_uprun <= 0; m_dnrun <= 0; m_clean <= 0; m_bad <= 1'b1; m_ool <= 1'b1;
        end else begin
            automatic bit w = is_wide(up_i, dn_i, m_uprun, m_dnrun);
            m_uprun <= up_i ? m_uprun + 1 : 0;
            m_dnrun <= dn_i ? m_dnrun + 1 : 0;
            m_bad   <= ref_tick ? w : (m_bad | w);
            if (w) begin
                m_ool <= 1'b1; m_clean <= 0;
            end else if (ref_tick && m_ool) begin
                if (m_bad) m_clean <= 0;
                else if (m_clean + 1 == REL) begin m_ool <= 1'b0; m_clean <= 0; end
                else m_clean <= m_clean + 1;
            end
        end
    end

    task automatic check(string req, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    // R6 every cycle against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R6 ool_status", ool_status, m_ool);
            check("R6 lock_fail_n", lock_fail_n, !m_ool);
        end
    end

    // one reference period: tick on first sample, pulses starting at given offsets
    task automatic ref_period(int wu, int ou, int wd, int od);
        for (int i = 0; i < REF_LEN; i++) begin
            ref_tick = (i == 0);
            if (i == ou && wu > 0) rem_up = wu;
            if (i == od && wd > 0) rem_dn = wd;
            up_i = (rem_up > 0);
            dn_i = (rem_dn > 0);
            if (rem_up > 0) rem_up--;
            if (rem_dn > 0) rem_dn--;
            @(negedge clk);
        end
        ref_tick = 1'b0; up_i = 1'b0; dn_i = 1'b0;
    endtask

    task automatic clean_periods(int n);
        for (int k = 0; k < n; k++) ref_period(0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R7 reset ool_status", ool_status, 1'b1);
        check("R7 reset lock_fail_n", lock_fail_n, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        clean_periods(REL);
        check("R7 partial period not counted", ool_status, 1'b1);
        clean_periods(1);
        check("R4 release after REL clean periods", ool_status, 1'b0);
        ref_period(TH, 3, 0, 0);
        check("R2 width equal threshold keeps lock", ool_status, 1'b0);
        ref_period(TH + 1, 3, 0, 0);
        check("R2 width above threshold sets flag", ool_status, 1'b1);
        clean_periods(REL);
        check("R5 one short of release", ool_status, 1'b1);
        ref_period(0, 0, TH + 1, 5);
        clean_periods(REL);
        check("R5 restart after error", ool_status, 1'b1);
        clean_periods(1);
        check("R5 release after restart", ool_status, 1'b0);
        ref_period(0, 0, TH, 7);
        check("R3 dn equal threshold keeps lock", ool_status, 1'b0);
        ref_period(0, 0, TH + 1, 7);
        check("R3 dn above threshold sets flag", ool_status, 1'b1);
        clean_periods(REL + 1);
        ref_period(TH, 2, TH + 2, 2);
        check("R1 wider strobe decides", ool_status, 1'b1);
        clean_periods(REL + 1);
        check("R1 relocked", lock_fail_n, 1'b1);
        ref_period(TH + 5, REF_LEN - 15, 0, 0);
        check("R8 straddle before tick", ool_status, 1'b0);
        ref_period(0, 0, 0, 0);
        check("R8 straddle measured across tick", ool_status, 1'b1);
        clean_periods(REL + 1);
        for (int n = 0; n < 200; n++) begin
            automatic int big = ($urandom % 4 == 0);
            automatic int wu = big ? $urandom_range(TH - 2, TH + 4) : $urandom_range(0, TH);
            automatic int wd = $urandom_range(0, TH - 1);
            ref_period(wu, $urandom_range(0, REF_LEN - 1), wd, $urandom_range(0, REF_LEN - 1));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule